// File: doc/BRIEF.md
# Nibble-Bus Memory Target

This block is the target side of a 4-bit multiplexed host bus, clocked by the bus clock. It samples the shared nibble lines every clock. From the idle state it looks for one of two start codes, one for a read and one for a write. It then takes a one-clock device-select nibble, seven address nibbles and a one-clock size nibble. A write also carries a two-clock data byte at this point.

After a two-clock turnaround, the target takes the bus. It presents the captured address to a local byte memory port and drives sync nibbles. These are wait codes while the port is busy, then either a ready code or an error code. A read returns one byte over two clocks. Every cycle ends with a two-clock handback turnaround.

A frame-abort input returns the block to idle from any state and drops the bus output-enable in the same clock. A cycle that selects another device, or asks for a size other than a single byte, is ignored until the host aborts it.

Top module: `nbus_mem_target`

## Requirements
- R1: In idle, a nibble of 1101b starts a read cycle and 1110b starts a write cycle. Any other nibble, including the idle value 0000b, leaves the block idle with `bus_oe` low and `mem_req` low.
- R2: The clock after the start code carries the select nibble. If it differs from `strap_id`, the block stays silent until `abort`: no `bus_oe` and no `mem_req`.
- R3: The next seven clocks carry the 28-bit address, bits 27:24 first and bits 3:0 last. It appears unchanged on `mem_addr` while `mem_req` is high.
- R4: The clock after the address carries the size nibble. Only 0000b (single byte) is served. Any other value makes the block stay silent, as in R2.
- R5: In a write cycle, the two clocks after the size carry the data byte, bits 3:0 first and bits 7:4 second. The byte appears on `mem_wdata` with `mem_we` high.
- R6: The two clocks after the header (after the size for reads, after the data for writes) are a turnaround in which `bus_oe` stays low.
- R7: From the third clock after the header, `bus_oe` is high and `mem_req` is high until the port answers. In each clock without `mem_ready` or `mem_err`, the target drives a wait code: 0101b for the first LONG_AFTER such clocks and 0110b after that. In the clock where `mem_ready` is high, it drives 0000b.
- R8: In the clock where `mem_err` is high, the target drives 1010b. No data follows; the handback turnaround of R10 follows at once.
- R9: After a ready sync in a read cycle, the next two clocks drive the byte that `mem_rdata` held in the ready clock, bits 3:0 first and bits 7:4 second.
- R10: The final turnaround drives 1111b with `bus_oe` high for one clock, then releases the bus for one clock. The following clock accepts a new start code.
- R11: `abort` high forces `bus_oe` low in the same clock. The block is idle from the next clock on, with `mem_req` low, and accepts a new start code.
- R12: While `mem_req` is high and the port has not answered, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable.
- R13: After reset, `bus_oe` and `mem_req` are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_id | input | 4 | Device number this target answers to |
| abort | input | 1 | Frame abort, returns the block to idle |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| bus_out | output | 4 | Nibble the target drives |
| bus_oe | output | 1 | Output enable for `bus_out` |
| mem_req | output | 1 | Local memory request, held until ready or error |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 28 | Captured byte address |
| mem_wdata | output | 8 | Captured write byte |
| mem_rdata | input | 8 | Read byte from the local port |
| mem_ready | input | 1 | Local port completes the request |
| mem_err | input | 1 | Local port reports failure |

## Verification
The bound checker watches the local handshake and the sync phase on every clock. It checks that a pending request holds its address and data, that an unanswered request shows only wait codes, and that a ready or error answer is followed by the right nibble in the next clock. It also checks that `abort` drops the output-enable at once. The nibble ordering of address and data, the silence after a foreign select or an unsupported size, the switch from short to long wait, and the turnaround timing are frame-level sequences. Only the bench's host scenarios against its own byte memory can show those.

// File: rtl/nbus_mem_target.sv
module nbus_mem_target #(
  parameter int ADDR_NIBS  = 7,
  parameter int LONG_AFTER = 4,
  localparam int ADDR_W = 4 * ADDR_NIBS,
  localparam int AC_W   = $clog2(ADDR_NIBS),
  localparam int WC_W   = $clog2(LONG_AFTER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        strap_id,
  input  logic              abort,
  input  logic [3:0]        bus_in,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  input  logic              mem_err
);

  localparam logic [3:0] CODE_RD    = 4'b1101;
  localparam logic [3:0] CODE_WR    = 4'b1110;
  localparam logic [3:0] SYNC_OK    = 4'b0000;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;
  localparam logic [3:0] SYNC_FAIL  = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_ADR, S_SIZ, S_WD0, S_WD1, S_TA0, S_TA1,
    S_SYN, S_RD0, S_RD1, S_HT0, S_HT1, S_LOCK
  } st_t;

  st_t               state;
  logic              is_wr;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata, rdata;
  logic [AC_W-1:0]   acnt;
  logic [WC_W-1:0]   wcnt;
  logic              long_wait;

  assign long_wait = (wcnt >= WC_W'(LONG_AFTER));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      is_wr <= 1'b0;
      addr  <= '0;
      wdata <= '0;
      rdata <= '0;
      acnt  <= '0;
      wcnt  <= '0;
    end else if (abort) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: begin
          if (bus_in == CODE_RD) begin
            state <= S_SEL;
            is_wr <= 1'b0;
          end else if (bus_in == CODE_WR) begin
            state <= S_SEL;
            is_wr <= 1'b1;
          end
        end
        S_SEL: begin
          acnt  <= '0;
          state <= (bus_in == strap_id) ? S_ADR : S_LOCK;
        end
        S_ADR: begin
          addr <= {addr[ADDR_W-5:0], bus_in};
          acnt <= acnt + 1'b1;
          if (acnt == AC_W'(ADDR_NIBS - 1)) state <= S_SIZ;
        end
        S_SIZ: begin
          if (bus_in != 4'b0000) state <= S_LOCK;
          else                   state <= is_wr ? S_WD0 : S_TA0;
        end
        S_WD0: begin
          wdata[3:0] <= bus_in;
          state      <= S_WD1;
        end
        S_WD1: begin
          wdata[7:4] <= bus_in;
          state      <= S_TA0;
        end
        S_TA0: state <= S_TA1;
        S_TA1: begin
          wcnt  <= '0;
          state <= S_SYN;
        end
        S_SYN: begin
          if (mem_err) begin
            state <= S_HT0;
          end else if (mem_ready) begin
            rdata <= mem_rdata;
            state <= is_wr ? S_HT0 : S_RD0;
          end else if (!long_wait) begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_RD0:  state <= S_RD1;
        S_RD1:  state <= S_HT0;
        S_HT0:  state <= S_HT1;
        S_HT1:  state <= S_IDLE;
        S_LOCK: state <= S_LOCK;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_SYN:   bus_out = mem_err   ? SYNC_FAIL :
                         mem_ready ? SYNC_OK   :
                         long_wait ? SYNC_LONG : SYNC_SHORT;
      S_RD0:   bus_out = rdata[3:0];
      S_RD1:   bus_out = rdata[7:4];
      S_HT0:   bus_out = 4'b1111;
      default: bus_out = 4'b0000;
    endcase
  end

  assign bus_oe = !abort && (state == S_SYN || state == S_RD0 ||
                             state == S_RD1 || state == S_HT0);
  assign mem_req   = (state == S_SYN);
  assign mem_we    = is_wr;
  assign mem_addr  = addr;
  assign mem_wdata = wdata;

endmodule

// File: rtl/nbus_mem_target_chk.sv
module nbus_mem_target_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort,
  input logic [3:0]        bus_out,
  input logic              bus_oe,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic [7:0]        mem_rdata,
  input logic              mem_ready,
  input logic              mem_err
);

  a_r11_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !bus_oe);

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !mem_req);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !mem_err && !abort) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r7_wait_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !mem_err && !abort) |->
      (bus_oe && (bus_out == 4'b0101 || bus_out == 4'b0110)));

  a_r8_error_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_err && !abort) |=>
      (abort || (bus_oe && bus_out == 4'b1111 && !mem_req)));

  a_r9_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !mem_err && !mem_we && !abort) |=>
      (abort || (bus_oe && bus_out == $past(mem_rdata[3:0]))));

endmodule

bind nbus_mem_target nbus_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .bus_out(bus_out), .bus_oe(bus_oe),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err)
);

// File: tb/nbus_mem_target_bench.sv
`timescale 1ns/100ps
module nbus_mem_target_bench;

  localparam int LONG_AFTER = 4;
  localparam logic [3:0] ID = 4'b0110;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        abort = 1'b0;
  logic [3:0]  bus_in = 4'b0000;
  logic [3:0]  bus_out;
  logic        bus_oe, mem_req, mem_we, mem_ready, mem_err;
  logic [27:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int          mem_lat = 0;
  logic        err_inj = 1'b0;
  int          lat_cnt;
  logic [7:0]  mem [256];
  logic [7:0]  shadow [256];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          reported = 0;

  always #2.5 clk = ~clk;

  nbus_mem_target #(.ADDR_NIBS(7), .LONG_AFTER(LONG_AFTER)) u_nbus_mem_target (
    .clk(clk), .rst_n(rst_n), .strap_id(ID), .abort(abort), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .mem_err(mem_err)
  );

  assign mem_ready = mem_req && !err_inj && (lat_cnt == mem_lat);
  assign mem_err   = mem_req &&  err_inj && (lat_cnt == mem_lat);
  assign mem_rdata = mem[mem_addr[7:0]];

  initial for (int i = 0; i < 256; i++) begin
    mem[i]    = 8'(i * 7 + 3);
    shadow[i] = 8'(i * 7 + 3);
  end

  always_ff @(posedge clk) begin
    if (!mem_req) lat_cnt <= 0;
    else          lat_cnt <= lat_cnt + 1;
    if (mem_req && mem_ready && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic tick(input logic [3:0] n);
    @(negedge clk);
    bus_in = n;
    #1;
  endtask

  task automatic header(input bit we, input logic [27:0] a, input logic [3:0] id, input logic [3:0] sz);
    tick(we ? 4'b1110 : 4'b1101);
    tick(id);
    for (int i = 6; i >= 0; i--) tick(a[i*4 +: 4]);
    tick(sz);
  endtask

  task automatic run_cycle(input bit we, input logic [27:0] a, input logic [7:0] wd,
                           input int lat, input bit err);
    logic [7:0] exp_rd;
    mem_lat = lat;
    err_inj = err;
    exp_rd  = shadow[a[7:0]];
    header(we, a, ID, 4'b0000);
    if (we) begin
      tick(wd[3:0]);
      tick(wd[7:4]);
    end
    for (int t = 0; t < 2; t++) begin
      tick(4'hF);
      check(!bus_oe, "R6 turnaround released", 32'(bus_oe), 0);
    end
    for (int k = 0; k <= lat; k++) begin
      logic [3:0] exp_code;
      tick(4'h0);
      if (k < lat) exp_code = (k < LONG_AFTER) ? 4'b0101 : 4'b0110;
      else         exp_code = err ? 4'b1010 : 4'b0000;
      check(bus_oe && bus_out == exp_code, err && k == lat ? "R8 error sync" : "R7 sync code",
            32'({bus_oe, bus_out}), 32'({1'b1, exp_code}));
      check(mem_req && mem_addr == a, "R3 address order", 32'(mem_addr), 32'(a));
      if (we) check(mem_we && mem_wdata == wd, "R5 write byte", 32'({mem_we, mem_wdata}), 32'({1'b1, wd}));
    end
    if (we && !err) shadow[a[7:0]] = wd;
    if (!we && !err) begin
      tick(4'h0);
      check(bus_oe && bus_out == exp_rd[3:0], "R9 read low nibble", 32'(bus_out), 32'(exp_rd[3:0]));
      tick(4'h0);
      check(bus_oe && bus_out == exp_rd[7:4], "R9 read high nibble", 32'(bus_out), 32'(exp_rd[7:4]));
    end
    tick(4'h0);
    check(bus_oe && bus_out == 4'hF, "R10 handback drive", 32'({bus_oe, bus_out}), 32'h1F);
    tick(4'h0);
    check(!bus_oe && !mem_req, "R10 handback release", 32'(bus_oe), 0);
    err_inj = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [27:0] addr;
    logic [7:0]  data;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 28'h1234567, 8'hA5, 4'd0},
    '{1'b0, 28'h1234567, 8'h00, 4'd1},
    '{1'b1, 28'hFEDCBA9, 8'h3C, 4'd2},
    '{1'b0, 28'h00000A9, 8'h00, 4'd0},
    '{1'b1, 28'h8000001, 8'h0F, 4'd5},
    '{1'b0, 28'h8000001, 8'h00, 4'd7},
    '{1'b0, 28'h0ABCD5E, 8'h00, 4'd3},
    '{1'b1, 28'h7FFFFFF, 8'hF0, 4'd4},
    '{1'b0, 28'h7FFFFFF, 8'h00, 4'd0}
  };

  task automatic expect_silent(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick(4'h0);
      check(!bus_oe && !mem_req, tag, 32'({bus_oe, mem_req}), 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!bus_oe && !mem_req, "R13 reset outputs", 32'({bus_oe, mem_req}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(4'h0);
    check(!bus_oe && !mem_req, "R13 idle after reset", 32'({bus_oe, mem_req}), 0);

    foreach (VEC[i]) run_cycle(VEC[i].we, VEC[i].addr, VEC[i].data, int'(VEC[i].lat), 1'b0);

    tick(4'b0101);
    tick(4'b1111);
    tick(4'b0011);
    expect_silent(12, "R1 stray start ignored");
    run_cycle(1'b0, 28'h0000A00, 8'h00, 0, 1'b0);

    header(1'b0, 28'h1234567, ID ^ 4'b0001, 4'b0000);
    expect_silent(8, "R2 foreign select silent");
    @(negedge clk); abort = 1'b1; #1;
    @(negedge clk); abort = 1'b0;
    run_cycle(1'b1, 28'h55555AA, 8'h69, 1, 1'b0);

    header(1'b0, 28'h00000AA, ID, 4'b0001);
    expect_silent(8, "R4 size not single byte");
    @(negedge clk); abort = 1'b1; #1;
    @(negedge clk); abort = 1'b0;
    run_cycle(1'b0, 28'h00000AA, 8'h00, 2, 1'b0);

    run_cycle(1'b0, 28'h0000011, 8'h00, 2, 1'b1);
    run_cycle(1'b1, 28'h0000022, 8'hEE, 1, 1'b1);
    run_cycle(1'b0, 28'h0000022, 8'h00, 0, 1'b0);

    mem_lat = 10;
    header(1'b0, 28'h0000033, ID, 4'b0000);
    tick(4'hF); tick(4'hF);
    tick(4'h0); tick(4'h0);
    check(bus_oe && mem_req, "R7 waiting before abort", 32'({bus_oe, mem_req}), 3);
    @(negedge clk); abort = 1'b1; #1;
    check(!bus_oe, "R11 abort drops enable", 32'(bus_oe), 0);
    @(negedge clk); abort = 1'b0; #1;
    check(!bus_oe && !mem_req, "R11 idle after abort", 32'({bus_oe, mem_req}), 0);
    run_cycle(1'b0, 28'h0000033, 8'h00, 1, 1'b0);

    report();
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

endmodule